// File: doc/BRIEF.md
# Processor Throttle Event Aggregator

This block merges seven digital trigger flags into one active-low throttle pulse for a host processor. The flags are an independent comparator, critical input current, nominal input current, battery discharge current, system voltage droop, a battery-present pin and an adapter-good pin. Each flag passes through a seven-bit enable mask. The comparator and discharge flags first pass through a selectable deglitch filter that delays assertion only. The battery-present and adapter-good flags are turned into single-cycle one-shots on one edge each.

Once any enabled event fires, the output is held low for a minimum window counted in microsecond ticks. Every newly arriving event restarts that window. The output does not return high while any enabled event is still active. Each event seen during the pulse sets a bit in a sticky status vector, which the host clears with a strobe. All durations are parameters counted in ticks of `tick_us_i`.

Top module: `throttle_event_agg`

## Requirements
- R1: Mask and status bits use this mapping: bit 6 comparator, bit 5 critical current, bit 4 nominal current, bit 3 discharge current, bit 2 system voltage, bit 1 battery-present, bit 0 adapter-good. Any event whose mask bit is set drives `throttle_n_o` low on the clock edge after it is seen.
- R2: While `mask_i` is all zero, `throttle_n_o` never goes low.
- R3: While `adp_present_i` is 0, events on bits 5, 4, 1 and 0 are ignored whatever the mask holds. Bits 6, 3 and 2 still act.
- R4: After the last newly arriving event, the pulse stays low until the timer has counted `MIN_PULSE_US` ticks. It returns high on the first edge after that at which no enabled event is active.
- R5: While any enabled event stays active, the pulse does not end.
- R6: A new enabled event arriving during the pulse restarts the minimum-width timer from zero.
- R7: The battery-present event is a one-cycle shot on a 0-to-1 transition of `batpres_i`. The adapter-good event is a one-cycle shot on a 1-to-0 transition of `acok_i`. Steady levels cause nothing.
- R8: The discharge event asserts only after `dchg_i` has stayed high for the selected number of ticks: 00 = `DCHG_DG0_US` (1.6 ms), 01 = `DCHG_DG1_US` (100 µs), 10 = `DCHG_DG2_US` (6 ms), 11 = `DCHG_DG3_US` (12 ms). It releases at once when `dchg_i` falls. A shorter glitch never fires.
- R9: The comparator output equals `cmp_above_i` when `cmp_pol_i` = 1 and its inverse when `cmp_pol_i` = 0. The comparator event is the comparator output being low. Its deglitch select is 00 = disabled (never fires), 01 = `CMP_DG1_US` (1 µs), 10 = `CMP_DG2_US` (2 ms), 11 = `CMP_DG3_US` (5 s). The delay applies only on assertion.
- R10: The status vector is sticky. Each enabled event that fires sets its bit, and bits are never cleared while no clear is accepted.
- R11: `clr_status_i` clears the status only while `throttle_n_o` is high. During a pulse it has no effect.
- R12: After reset, `throttle_n_o` is 1 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle strobe per microsecond |
| mask_i | input | 7 | Event enable mask |
| adp_present_i | input | 1 | Adapter present; gates bits 5, 4, 1, 0 |
| cmp_above_i | input | 1 | Comparator input above its threshold |
| cmp_pol_i | input | 1 | Comparator output polarity |
| cmp_dg_sel_i | input | 2 | Comparator deglitch select |
| crit_i | input | 1 | Critical input current flag |
| nom_i | input | 1 | Nominal input current flag |
| dchg_i | input | 1 | Discharge current flag |
| dchg_dg_sel_i | input | 2 | Discharge deglitch select |
| vsys_i | input | 1 | System voltage droop flag |
| batpres_i | input | 1 | Battery-present pin level |
| acok_i | input | 1 | Adapter-good pin level |
| clr_status_i | input | 1 | Status clear strobe |
| throttle_n_o | output | 1 | Active-low throttle pulse |
| status_o | output | 7 | Sticky event status |

## Verification
A behavioural reference model predicts the pulse and the status on every cycle. The stimulus includes single events under one-hot masks, which show that each bit maps to the right source. A zero mask and an absent adapter show which sources are gated. Held levels and late second events separate stretching from restarting. Glitches one tick shorter than each deglitch setting, against holds longer than it, show the assertion delay of every select code, with both comparator polarities. Clear strobes issued inside and outside a pulse show when the status may drop. A phase with a sparse tick shows that timing follows the tick and not the clock.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  localparam int N_EV     = 7;
  localparam int EV_CMP   = 6;
  localparam int EV_CRIT  = 5;
  localparam int EV_NOM   = 4;
  localparam int EV_DCHG  = 3;
  localparam int EV_VSYS  = 2;
  localparam int EV_BATP  = 1;
  localparam int EV_ACOK  = 0;
  // sources that stay live without an adapter
  localparam logic [N_EV-1:0] NO_ADP_MASK = 7'b1001100;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tea_deglitch.sv
module tea_deglitch #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             filt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             filt_q;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!raw_i || !en_i) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (tick_i && !filt_q) begin
      if (cnt_inc >= {1'b0, lim_i}) filt_q <= 1'b1;
      else                          cnt_q  <= cnt_inc[CNT_W-1:0];
    end
  end

  assign filt_o = filt_q;

  AST_DG_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_i || !en_i) |=> !filt_o); // R8
  AST_DG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_o && raw_i && en_i) |=> filt_o); // R9
endmodule

// File: rtl/tea_edge_shot.sv
module tea_edge_shot #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic shot_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RISING ? 1'b0 : 1'b1;
    else         prev_q <= lvl_i;
  end

  generate
    if (RISING) begin : g_rise
      assign shot_o = lvl_i & ~prev_q;
    end else begin : g_fall
      assign shot_o = ~lvl_i & prev_q;
    end
  endgenerate

  AST_SHOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shot_o |=> !shot_o); // R7
endmodule

// File: rtl/tea_pulse_ctl.sv
module tea_pulse_ctl #(
  parameter int N_EV         = 7,
  parameter int MIN_PULSE_US = 10000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_EV-1:0] act_i,
  output logic            active_o
);
  localparam int CW = $clog2(MIN_PULSE_US + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_PULSE_US);

  logic [N_EV-1:0] act_q;
  logic [CW-1:0]   cnt_q;
  logic            active_q;
  logic            arrive;

  assign arrive = |(act_i & ~act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      act_q <= act_i;
      if (arrive) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (cnt_q == LIM && act_i == '0) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else if (tick_i && cnt_q != LIM) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;

  AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(cnt_q) == LIM); // R4
  AST_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && act_i != '0) |=> active_q); // R5
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(act_i & ~act_q)) |=> (active_q && cnt_q == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && act_i == '0) |=> !active_q); // R1
endmodule

// File: rtl/throttle_event_agg.sv
module throttle_event_agg
  import throttle_pkg::*;
#(
  parameter int MIN_PULSE_US = 10000,
  parameter int DCHG_DG0_US  = 1600,
  parameter int DCHG_DG1_US  = 100,
  parameter int DCHG_DG2_US  = 6000,
  parameter int DCHG_DG3_US  = 12000,
  parameter int CMP_DG1_US   = 1,
  parameter int CMP_DG2_US   = 2000,
  parameter int CMP_DG3_US   = 5000000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_us_i,
  input  logic [N_EV-1:0] mask_i,
  input  logic            adp_present_i,
  input  logic            cmp_above_i,
  input  logic            cmp_pol_i,
  input  logic [1:0]      cmp_dg_sel_i,
  input  logic            crit_i,
  input  logic            nom_i,
  input  logic            dchg_i,
  input  logic [1:0]      dchg_dg_sel_i,
  input  logic            vsys_i,
  input  logic            batpres_i,
  input  logic            acok_i,
  input  logic            clr_status_i,
  output logic            throttle_n_o,
  output logic [N_EV-1:0] status_o
);
  localparam int MAX_US = max_int(max_int(max_int(DCHG_DG0_US, DCHG_DG1_US),
                                          max_int(DCHG_DG2_US, DCHG_DG3_US)),
                                  max_int(max_int(CMP_DG1_US, CMP_DG2_US), CMP_DG3_US));
  localparam int CNT_W = $clog2(MAX_US + 2);

  logic [CNT_W-1:0] dchg_lim, cmp_lim;
  logic             cmp_out, cmp_en, cmp_f, dchg_f, bp_shot, ao_shot, active;
  logic [N_EV-1:0]  ev, eff_mask, act, status_q;

  always_comb begin
    unique case (dchg_dg_sel_i)
      2'b00:   dchg_lim = CNT_W'(DCHG_DG0_US);
      2'b01:   dchg_lim = CNT_W'(DCHG_DG1_US);
      2'b10:   dchg_lim = CNT_W'(DCHG_DG2_US);
      default: dchg_lim = CNT_W'(DCHG_DG3_US);
    endcase
    unique case (cmp_dg_sel_i)
      2'b01:   cmp_lim = CNT_W'(CMP_DG1_US);
      2'b10:   cmp_lim = CNT_W'(CMP_DG2_US);
      default: cmp_lim = CNT_W'(CMP_DG3_US);
    endcase
  end

  assign cmp_out = cmp_pol_i ? cmp_above_i : ~cmp_above_i;
  assign cmp_en  = (cmp_dg_sel_i != 2'b00);

  tea_deglitch #(.CNT_W(CNT_W)) u_cmp_dg (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i), .en_i(cmp_en),
    .raw_i(~cmp_out), .lim_i(cmp_lim), .filt_o(cmp_f));

  tea_deglitch #(.CNT_W(CNT_W)) u_dchg_dg (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i), .en_i(1'b1),
    .raw_i(dchg_i), .lim_i(dchg_lim), .filt_o(dchg_f));

  tea_edge_shot #(.RISING(1'b1)) u_bp_shot (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(batpres_i), .shot_o(bp_shot));

  tea_edge_shot #(.RISING(1'b0)) u_ao_shot (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(acok_i), .shot_o(ao_shot));

  always_comb begin
    ev          = '0;
    ev[EV_CMP]  = cmp_f;
    ev[EV_CRIT] = crit_i;
    ev[EV_NOM]  = nom_i;
    ev[EV_DCHG] = dchg_f;
    ev[EV_VSYS] = vsys_i;
    ev[EV_BATP] = bp_shot;
    ev[EV_ACOK] = ao_shot;
  end

  assign eff_mask = adp_present_i ? mask_i : (mask_i & NO_ADP_MASK);
  assign act      = ev & eff_mask;

  tea_pulse_ctl #(.N_EV(N_EV), .MIN_PULSE_US(MIN_PULSE_US)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_us_i), .act_i(act), .active_o(active));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((clr_status_i && !active) ? '0 : status_q) | act;
  end

  assign throttle_n_o = ~active;
  assign status_o     = status_q;

  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_n_o && mask_i == '0) |=> throttle_n_o); // R2
  AST_ADP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_n_o && !adp_present_i && !mask_i[EV_CMP] && !mask_i[EV_DCHG] && !mask_i[EV_VSYS])
      |=> throttle_n_o); // R3
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_status_i || !throttle_n_o) |=> ((status_o & $past(status_o)) == $past(status_o))); // R10
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && throttle_n_o && act == '0) |=> status_o == '0); // R11
endmodule

// File: tb/throttle_event_agg_tb.sv
module throttle_event_agg_tb_top;
  localparam int CLK_P = 10;
  localparam int PW = 20;
  localparam int D0 = 10, D1 = 3, D2 = 25, D3 = 40;
  localparam int C1 = 1, C2 = 6, C3 = 30;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [6:0] mask = 0;
  logic adp = 1, above = 0, pol = 0, crit = 0, nom = 0, dchg = 0, vsys = 0;
  logic batp = 0, acok = 1, clr = 0;
  logic [1:0] csel = 2'b01, dsel = 2'b01;
  logic thr_n;
  logic [6:0] status;
  int errors = 0, checks = 0, tick_div = 1, tick_cnt = 0;
  string phase = "R12";

  always #(CLK_P/2) clk = ~clk;

  throttle_event_agg #(
    .MIN_PULSE_US(PW), .DCHG_DG0_US(D0), .DCHG_DG1_US(D1), .DCHG_DG2_US(D2),
    .DCHG_DG3_US(D3), .CMP_DG1_US(C1), .CMP_DG2_US(C2), .CMP_DG3_US(C3)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .mask_i(mask), .adp_present_i(adp),
    .cmp_above_i(above), .cmp_pol_i(pol), .cmp_dg_sel_i(csel), .crit_i(crit), .nom_i(nom),
    .dchg_i(dchg), .dchg_dg_sel_i(dsel), .vsys_i(vsys), .batpres_i(batp), .acok_i(acok),
    .clr_status_i(clr), .throttle_n_o(thr_n), .status_o(status));

  // behavioural reference model
  bit m_active, m_cf, m_df, m_bp, m_ao;
  bit [6:0] m_status, m_actq;
  int m_cnt, m_cc, m_dc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_cf = 0; m_df = 0; m_bp = 0; m_ao = 1;
      m_status = 0; m_actq = 0; m_cnt = 0; m_cc = 0; m_dc = 0;
    end else begin
      bit [6:0] e, act;
      bit craw;
      int dl, cl;
      e = {m_cf, crit, nom, m_df, vsys, batp && !m_bp, !acok && m_ao};
      act = e & (adp ? mask : (mask & 7'b1001100));
      if (clr && !m_active) m_status = 0;
      m_status |= act;
      if ((act & ~m_actq) != 0) begin
        m_active = 1; m_cnt = 0;
      end else if (m_active) begin
        if (m_cnt >= PW && act == 0) begin m_active = 0; m_cnt = 0; end
        else if (tick && m_cnt < PW) m_cnt++;
      end
      m_actq = act; m_bp = batp; m_ao = acok;
      dl = (dsel == 0) ? D0 : (dsel == 1) ? D1 : (dsel == 2) ? D2 : D3;
      if (!dchg) begin m_dc = 0; m_df = 0; end
      else if (tick && !m_df) begin if (m_dc + 1 >= dl) m_df = 1; else m_dc++; end
      craw = pol ? !above : above;
      cl = (csel == 1) ? C1 : (csel == 2) ? C2 : C3;
      if (!craw || csel == 0) begin m_cc = 0; m_cf = 0; end
      else if (tick && !m_cf) begin if (m_cc + 1 >= cl) m_cf = 1; else m_cc++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    tick = (tick_cnt == 0);
    if (rst_n) begin
      chk(thr_n == !m_active, {phase, " pulse"}, thr_n, !m_active);
      chk(status == m_status, {phase, " status"}, status, m_status);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    clr = 1; step(1); clr = 0; step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    chk(thr_n == 1'b1, "R12 reset pulse", thr_n, 1);
    chk(status == 7'h00, "R12 reset status", status, 0);
    rst_n = 1; step(2);

    phase = "R2";
    mask = 0;
    crit = 1; nom = 1; vsys = 1; dchg = 1; above = 1; batp = 1; acok = 0; step(10);
    crit = 0; nom = 0; vsys = 0; dchg = 0; above = 0; batp = 0; acok = 1; step(5);
    chk(thr_n == 1'b1, "R2 zero mask", thr_n, 1);

    phase = "R1";
    for (int i = 0; i < 7; i++) begin
      mask = 7'(1 << i); step(1);
      case (i)
        6: begin above = 1; step(4); above = 0; end
        5: begin crit = 1; step(2); crit = 0; end
        4: begin nom = 1; step(2); nom = 0; end
        3: begin dchg = 1; step(6); dchg = 0; end
        2: begin vsys = 1; step(2); vsys = 0; end
        1: begin batp = 1; step(3); batp = 0; end
        default: begin acok = 0; step(3); acok = 1; end
      endcase
      step(PW + 10);
      chk(status == 7'(1 << i), "R1 mapping", status, 1 << i);
      chk(thr_n == 1'b1, "R4 release", thr_n, 1);
      phase = "R11"; clear_status(); phase = "R1";
      chk(status == 0, "R11 idle clear", status, 0);
    end

    phase = "R3";
    adp = 0; mask = 7'h7F; step(1);
    crit = 1; nom = 1; step(3); crit = 0; nom = 0;
    batp = 1; step(2); batp = 0; acok = 0; step(2); acok = 1; step(3);
    chk(thr_n == 1'b1, "R3 gated", thr_n, 1);
    vsys = 1; step(1); vsys = 0; step(2);
    chk(thr_n == 1'b0, "R3 live source", thr_n, 0);
    step(PW + 5);
    chk(status == 7'b0000100, "R3 status", status, 7'b0000100);
    clear_status(); adp = 1;

    phase = "R5";
    vsys = 1; step(3 * PW); 
    chk(thr_n == 1'b0, "R5 stretch", thr_n, 0);
    vsys = 0; step(PW + 5);

    phase = "R6";
    crit = 1; step(1); crit = 0; step(PW - 5);
    nom = 1; step(1); nom = 0; step(PW - 3);
    chk(thr_n == 1'b0, "R6 restart", thr_n, 0);
    step(10);
    chk(thr_n == 1'b1, "R6 end", thr_n, 1);

    phase = "R7";
    batp = 1; step(PW + 5);
    chk(thr_n == 1'b1, "R7 level held", thr_n, 1);
    batp = 0; step(3);
    chk(thr_n == 1'b1, "R7 falling batpres", thr_n, 1);
    acok = 0; step(PW + 5); acok = 1; step(3);
    chk(thr_n == 1'b1, "R7 rising acok", thr_n, 1);
    clear_status();

    phase = "R8";
    mask = 7'b0001000;
    for (int s = 0; s < 4; s++) begin
      int lim;
      dsel = 2'(s);
      lim = (s == 0) ? D0 : (s == 1) ? D1 : (s == 2) ? D2 : D3;
      dchg = 1; step(lim - 1); dchg = 0; step(3);
      chk(thr_n == 1'b1, "R8 glitch", thr_n, 1);
      dchg = 1; step(lim + 4); dchg = 0; step(PW + 5);
      clear_status();
    end

    phase = "R9";
    mask = 7'b1000000;
    for (int p = 0; p < 2; p++) begin
      pol = p[0]; above = pol; step(2);
      csel = 2'b00; above = !pol; step(12); above = pol; step(2);
      chk(thr_n == 1'b1, "R9 disabled", thr_n, 1);
      csel = 2'b10; above = !pol; step(C2 - 2); above = pol; step(3);
      above = !pol; step(C2 + 4); above = pol; step(PW + 5);
      csel = 2'b11; above = !pol; step(C3 + 3); above = pol; step(PW + 5);
      csel = 2'b01; above = !pol; step(2); above = pol; step(PW + 5);
      clear_status();
    end
    pol = 0; above = 0; step(2);

    phase = "R11";
    mask = 7'h7F;
    vsys = 1; step(1); vsys = 0; step(4);
    clr = 1; step(1); clr = 0; step(1);
    chk(status == 7'b0000100, "R11 clear in pulse", status, 7'b0000100);
    step(PW + 5);
    clear_status();

    phase = "R4";
    tick_div = 3;
    crit = 1; step(1); crit = 0; step(3 * PW + 10);
    tick_div = 1; step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule